// File: doc/BRIEF.md
# Restart Delay and Clock Supervisor

This block governs when a small processor core may run. After power-on reset, and again each time the core comes out of its low-power stop state, it counts bus cycles and only then raises the run enable. A configuration bit selects a long stabilisation wait of 4064 cycles or a short bypass of 4 cycles. The long wait is the reset default, so a power-on start always takes the full delay.

A clock supervisor runs from a separate, free-running slow reference clock. It exchanges a toggle handshake with the system clock domain. When the system clock stops answering for 8 reference periods, it raises a clock-failure reset for 16 reference periods. The supervisor is enabled by an ordinary enable bit or by a sticky force bit, which can only be cleared by reset. Entering stop with the supervisor enabled freezes the handshake, so it trips the failure reset.

The block also makes the watchdog tick. The source is either the bus clock divided by 2^PRE_W or an external timer tick. A 2-bit rate field divides that source further by 1, 4, 16 or 64.

Top module: `restartSup`

## Requirements
- R1: After rstN is released, coreRun is low for the first 4063 rising clk edges and high from the 4064th. The delay-enable bit (cfgRdata bit 0) reads 1 after reset.
- R2: When stopMode is sampled high while coreRun is high, coreRun is low after that edge. With cfgRdata bit 0 set when stopMode is later sampled low, coreRun rises on the 4064th rising edge at which stopMode is sampled low.
- R3: With cfgRdata bit 0 clear when stopMode is sampled low, coreRun rises on the 4th such edge.
- R4: The configuration register takes cfgWdata on a rising clk edge with cfgWe high. cfgRdata shows it without delay, with this layout: bit 0 delay enable, bit 1 monitor enable, bit 2 force monitor, bits 4:3 rate. After reset it reads 5'b00001.
- R5: With the monitor active, if the system clock stops, clkFailRst goes high 8 to 12 reference periods later. It then stays high for exactly 16 consecutive reference periods.
- R6: With bits 1 and 2 both clear, a stopped system clock never raises clkFailRst.
- R7: Once bit 2 is written as 1, it reads 1 until rstN, whatever is later written to it. While it is set, the monitor is active even with bit 1 clear.
- R8: Entering stop with the monitor active raises clkFailRst within 14 reference periods, even though clk keeps running.
- R9: With extTickSel low, wdTick is a one-cycle pulse every 2^PRE_W * 4^rate clk cycles.
- R10: With extTickSel high, wdTick pulses once for every 4^rate extTick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| refClk | input | 1 | Free-running slow reference clock for the supervisor |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 5 | Configuration write data |
| cfgRdata | output | 5 | Configuration read value |
| stopMode | input | 1 | High while the core requests or holds stop |
| coreRun | output | 1 | Core release after the restart delay |
| extTickSel | input | 1 | Selects the external tick as the watchdog source |
| extTick | input | 1 | External timer tick, one clk cycle wide |
| wdTick | output | 1 | Scaled watchdog tick pulse |
| clkFailRst | output | 1 | Clock-failure reset, reference domain |

## Verification
The restart release is exact in clk edges. The bench samples coreRun on the falling edge after the 4063rd and 4064th rising edges (after the 3rd and 4th for the short path), so both the edge just before the release and the release edge itself are pinned. A stop request drops coreRun on the next edge, and a configuration write shows on cfgRdata at the falling edge after the write edge. The failure reset crosses two synchronisers, so its rise has no single due cycle; the bench counts reference periods from the moment the clock stops and accepts a rise between the 8th and 12th period (14th for the stop-mode trip). The high run length must then be exactly 16. Watchdog periods are measured edge to edge between the second and third pulses after a rate change, which removes the scaler phase left by the earlier setting.

// File: rtl/restartSupPkg.sv
package restartSupPkg;
  localparam int CFG_W   = 5;
  localparam int B_DLY   = 0;
  localparam int B_MON   = 1;
  localparam int B_FORCE = 2;
  localparam int B_RATE  = 3;
  localparam int RATE_W  = 2;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_RUN  = 2'd1,
    PH_STOP = 2'd2
  } phase_t;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic cntLoad1;
    logic latchTgt;
    logic tgtLong;
  } dlyCtl_t;
endpackage

// File: rtl/restartSupCtrl.sv
module restartSupCtrl
  import restartSupPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWdata,
  input  logic                stopMode,
  input  logic                cntDone,
  output logic [CFG_W-1:0]    cfgRdata,
  output logic                coreRun,
  output logic                monActive,
  output logic                freeze,
  output logic [RATE_W-1:0]   rate,
  output dlyCtl_t             dlyCtl
);
  logic   delayEn, monEn, forceMon;
  phase_t phase, phaseNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayEn  <= 1'b1;
      monEn    <= 1'b0;
      forceMon <= 1'b0;
      rate     <= '0;
    end else if (cfgWe) begin
      delayEn  <= cfgWdata[B_DLY];
      monEn    <= cfgWdata[B_MON];
      forceMon <= forceMon | cfgWdata[B_FORCE];
      rate     <= cfgWdata[B_RATE +: RATE_W];
    end
  end

  always_comb begin
    cfgRdata              = '0;
    cfgRdata[B_DLY]       = delayEn;
    cfgRdata[B_MON]       = monEn;
    cfgRdata[B_FORCE]     = forceMon;
    cfgRdata[B_RATE +: RATE_W] = rate;
  end

  assign monActive = monEn | forceMon;

  always_comb begin
    phaseNxt = phase;
    dlyCtl   = '0;
    unique case (phase)
      PH_WAIT: begin
        if (cntDone) phaseNxt = PH_RUN;
        else dlyCtl.cntInc = 1'b1;
      end
      PH_RUN: begin
        if (stopMode) begin
          phaseNxt      = PH_STOP;
          dlyCtl.cntClr = 1'b1;
        end
      end
      PH_STOP: begin
        if (!stopMode) begin
          phaseNxt        = PH_WAIT;
          dlyCtl.cntLoad1 = 1'b1;
          dlyCtl.latchTgt = 1'b1;
          dlyCtl.tgtLong  = delayEn;
        end
      end
      default: phaseNxt = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WAIT;
    else       phase <= phaseNxt;
  end

  assign coreRun = (phase == PH_RUN);
  assign freeze  = (phase == PH_STOP) && monActive;

  AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[B_FORCE] |=> cfgRdata[B_FORCE]); // R7
  AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun && stopMode) |=> !coreRun); // R2
  AST_RUN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRun) |-> $past(cntDone)); // R1
endmodule

// File: rtl/restartSupPath.sv
module restartSupPath
  import restartSupPkg::*;
#(
  parameter int LONG_DLY  = 4064,
  parameter int SHORT_DLY = 4,
  parameter int PRE_W     = 15
)(
  input  logic              clk,
  input  logic              rstN,
  input  dlyCtl_t           dlyCtl,
  input  logic [RATE_W-1:0] rate,
  input  logic              extTickSel,
  input  logic              extTick,
  output logic              cntDone,
  output logic              wdTick
);
  localparam int DLY_W   = $clog2(LONG_DLY);
  localparam int SCALE_W = 2 * ((1 << RATE_W) - 1);

  logic [DLY_W-1:0]   cnt;
  logic               tgtLong;
  logic [PRE_W-1:0]   preCnt;
  logic [SCALE_W-1:0] scaleCnt, scaleMask;
  logic               baseTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      tgtLong <= 1'b1;
    end else begin
      if (dlyCtl.cntClr)        cnt <= '0;
      else if (dlyCtl.cntLoad1) cnt <= DLY_W'(1);
      else if (dlyCtl.cntInc)   cnt <= cnt + 1'b1;
      if (dlyCtl.latchTgt)      tgtLong <= dlyCtl.tgtLong;
    end
  end

  assign cntDone = tgtLong ? (cnt == DLY_W'(LONG_DLY - 1))
                           : (cnt == DLY_W'(SHORT_DLY - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign baseTick = extTickSel ? extTick : (&preCnt);

  generate
    for (genvar g = 0; g < SCALE_W / 2; g++) begin : g_mask
      assign scaleMask[2*g +: 2] = (32'(rate) > g) ? 2'b11 : 2'b00;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleCnt <= '0;
      wdTick   <= 1'b0;
    end else begin
      if (baseTick) scaleCnt <= scaleCnt + 1'b1;
      wdTick <= baseTick && ((scaleCnt & scaleMask) == scaleMask);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt < DLY_W'(LONG_DLY)); // R1
  AST_TICK_ON_BASE: assert property (@(posedge clk) disable iff (!rstN)
    wdTick |-> $past(baseTick)); // R9
endmodule

// File: rtl/restartSupMon.sv
module restartSupMon #(
  parameter int MISS_REFS = 8,
  parameter int HOLD_REFS = 16
)(
  input  logic clk,
  input  logic refClk,
  input  logic rstN,
  input  logic monActive,
  input  logic freeze,
  output logic clkFailRst
);
  localparam int IDLE_W = $clog2(MISS_REFS);
  localparam int HOLD_W = $clog2(HOLD_REFS + 1);

  logic [1:0]        reqSync, ackSync, monSync;
  logic              reqT, ackT, progress;
  logic [IDLE_W-1:0] idleCnt;
  logic [HOLD_W-1:0] holdCnt;

  // system clock side: echo the reference request unless frozen by stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      ackT    <= 1'b0;
    end else begin
      reqSync <= {reqSync[0], reqT};
      if (!freeze) ackT <= reqSync[1];
    end
  end

  assign progress = (ackSync[1] == reqT);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ackSync <= '0;
      monSync <= '0;
      reqT    <= 1'b0;
      idleCnt <= '0;
      holdCnt <= '0;
    end else begin
      ackSync <= {ackSync[0], ackT};
      monSync <= {monSync[0], monActive};
      if (progress) reqT <= ~reqT;
      if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
        idleCnt <= '0;
      end else if (monSync[1] && !progress) begin
        if (idleCnt == IDLE_W'(MISS_REFS - 1)) begin
          holdCnt <= HOLD_W'(HOLD_REFS);
          idleCnt <= '0;
        end else begin
          idleCnt <= idleCnt + 1'b1;
        end
      end else begin
        idleCnt <= '0;
      end
    end
  end

  assign clkFailRst = (holdCnt != '0);

  AST_HOLD_LIMIT: assert property (@(posedge refClk) disable iff (!rstN)
    holdCnt <= HOLD_W'(HOLD_REFS)); // R5
  AST_FAIL_AFTER_MISS: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(clkFailRst) |-> ($past(idleCnt) == IDLE_W'(MISS_REFS - 1))); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge refClk) disable iff (!rstN)
    (!monSync[1] && !clkFailRst) |=> !clkFailRst); // R6
endmodule

// File: rtl/restartSup.sv
module restartSup
  import restartSupPkg::*;
#(
  parameter int LONG_DLY  = 4064,
  parameter int SHORT_DLY = 4,
  parameter int PRE_W     = 15,
  parameter int MISS_REFS = 8,
  parameter int HOLD_REFS = 16
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClk,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             stopMode,
  output logic             coreRun,
  input  logic             extTickSel,
  input  logic             extTick,
  output logic             wdTick,
  output logic             clkFailRst
);
  dlyCtl_t           dlyCtl;
  logic              cntDone, monActive, freeze;
  logic [RATE_W-1:0] rate;

  restartSupCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .stopMode(stopMode), .cntDone(cntDone), .cfgRdata(cfgRdata),
    .coreRun(coreRun), .monActive(monActive), .freeze(freeze),
    .rate(rate), .dlyCtl(dlyCtl)
  );

  restartSupPath #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY), .PRE_W(PRE_W)) uPath (
    .clk(clk), .rstN(rstN), .dlyCtl(dlyCtl), .rate(rate),
    .extTickSel(extTickSel), .extTick(extTick),
    .cntDone(cntDone), .wdTick(wdTick)
  );

  restartSupMon #(.MISS_REFS(MISS_REFS), .HOLD_REFS(HOLD_REFS)) uMon (
    .clk(clk), .refClk(refClk), .rstN(rstN), .monActive(monActive),
    .freeze(freeze), .clkFailRst(clkFailRst)
  );
endmodule

// File: tb/tb_restartSup.sv
module tb_restartSup;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 45;
  localparam int TB_PRE_W   = 4;
  localparam int EXT_GAP    = 3;

  logic clk = 1'b0, refClk = 1'b0, clkOn = 1'b1;
  logic rstN, cfgWe, stopMode, extTickSel, extTick;
  logic [4:0] cfgWdata, cfgRdata;
  logic coreRun, wdTick, clkFailRst;
  int nChk = 0, nBad = 0, extCnt = 0;

  restartSup #(.PRE_W(TB_PRE_W)) dut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .stopMode(stopMode), .coreRun(coreRun),
    .extTickSel(extTickSel), .extTick(extTick), .wdTick(wdTick), .clkFailRst(clkFailRst)
  );

  initial forever begin #(CLK_PERIOD/2); if (clkOn) clk = ~clk; end
  initial forever #(REF_HALF) refClk = ~refClk;

  initial begin
    extTick = 1'b0;
    forever begin
      @(negedge clk);
      extCnt++;
      extTick = (extCnt % EXT_GAP == 0);
    end
  end

  // {ext, rate, expected period}
  localparam logic [18:0] WD_VEC [8] = '{
    {1'b0, 2'd0, 16'd16},  {1'b0, 2'd1, 16'd64},
    {1'b0, 2'd2, 16'd256}, {1'b0, 2'd3, 16'd1024},
    {1'b1, 2'd0, 16'd3},   {1'b1, 2'd1, 16'd12},
    {1'b1, 2'd2, 16'd48},  {1'b1, 2'd3, 16'd192}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [4:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic tickPeriod(output int period);
    int n = 0;
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!wdTick && n < 5000);
    end
    period = n;
  endtask

  task automatic refWait(input int n);
    repeat (n) @(negedge refClk);
  endtask

  // counts reference periods from now; reports first high index and run length
  task automatic failWatch(input int span, output int first, output int runLen);
    logic inRun = 1'b0;
    first = 0; runLen = 0;
    for (int i = 1; i <= span; i++) begin
      @(negedge refClk);
      if (clkFailRst && first == 0) begin first = i; inRun = 1'b1; end
      if (inRun) begin
        if (clkFailRst) runLen++;
        else inRun = 1'b0;
      end
    end
  endtask

  task automatic gateClk();
    @(negedge clk); clkOn = 1'b0;
  endtask

  task automatic ungateClk();
    clkOn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int per, first, runLen;
    rstN = 1'b0; cfgWe = 1'b0; cfgWdata = '0; stopMode = 1'b0; extTickSel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset cfg value", int'(cfgRdata), 1);
    chk("R1 coreRun low in reset", int'(coreRun), 0);
    chk("R5 failRst low in reset", int'(clkFailRst), 0);
    rstN = 1'b1;
    repeat (4063) @(posedge clk);
    @(negedge clk);
    chk("R1 coreRun low at edge 4063", int'(coreRun), 0);
    @(posedge clk); @(negedge clk);
    chk("R1 coreRun high at edge 4064", int'(coreRun), 1);

    cfgWrite(5'b10011);
    chk("R4 write readback", int'(cfgRdata), 5'b10011);

    // watchdog tick table, R9 internal rows and R10 external rows
    foreach (WD_VEC[i]) begin
      extTickSel = WD_VEC[i][18];
      cfgWrite({WD_VEC[i][17:16], 3'b001});
      tickPeriod(per);
      chk(WD_VEC[i][18] ? "R10 ext tick period" : "R9 int tick period",
          per, int'(WD_VEC[i][15:0]));
    end
    extTickSel = 1'b0;

    // stop and short wake, R2 then R3
    @(negedge clk); stopMode = 1'b1;
    @(negedge clk);
    chk("R2 coreRun drops on stop", int'(coreRun), 0);
    cfgWrite(5'b00000);
    @(negedge clk); stopMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 short wake low at edge 3", int'(coreRun), 0);
    @(posedge clk); @(negedge clk);
    chk("R3 short wake high at edge 4", int'(coreRun), 1);

    // stop and long wake, R2
    @(negedge clk); stopMode = 1'b1;
    cfgWrite(5'b00001);
    @(negedge clk); stopMode = 1'b0;
    repeat (4063) @(posedge clk);
    @(negedge clk);
    chk("R2 long wake low at edge 4063", int'(coreRun), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 long wake high at edge 4064", int'(coreRun), 1);

    // R6 monitor off, stopped clock
    gateClk();
    failWatch(30, first, runLen);
    chk("R6 no failure with monitor off", first, 0);
    ungateClk();

    // R5 monitor on, stopped clock
    cfgWrite(5'b00011);
    chk("R4 monitor bit readback", int'(cfgRdata), 5'b00011);
    refWait(4);
    gateClk();
    failWatch(30, first, runLen);
    chk("R5 failure onset in window", int'(first >= 8 && first <= 12), 1);
    chk("R5 failure hold length", runLen, 16);
    ungateClk();
    refWait(30);
    chk("R5 failure clears after clock returns", int'(clkFailRst), 0);

    // R8 stop with monitor active
    @(negedge clk); stopMode = 1'b1;
    failWatch(30, first, runLen);
    chk("R8 stop trips failure", int'(first >= 1 && first <= 14), 1);
    @(negedge clk); stopMode = 1'b0;
    cfgWrite(5'b00001);
    refWait(30);

    // R7 sticky force bit
    cfgWrite(5'b00101);
    chk("R7 force bit set", int'(cfgRdata[2]), 1);
    cfgWrite(5'b00001);
    chk("R7 force bit survives clear write", int'(cfgRdata[2]), 1);
    chk("R7 enable bit follows write", int'(cfgRdata[1]), 0);
    refWait(4);
    gateClk();
    failWatch(30, first, runLen);
    chk("R7 forced monitor trips", int'(first >= 8 && first <= 12), 1);
    ungateClk();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R7 force bit cleared by reset", int'(cfgRdata[2]), 0);
    rstN = 1'b1;

    summary();
    $finish;
  end
endmodule